// File: doc/BRIEF.md
# Register-Driven Serial Bus Write Engine

This block sends one write transaction on a two-wire serial bus to a peripheral that is reached only through an 8-bit control register. The block never drives bus pins itself. It issues a sequence of register writes, each one a strobe with a fixed register address and an 8-bit value. Within that value, bit 0 is the serial clock level and bit 1 is the serial data level. Bits 7:2 repeat a base value that the caller supplies. These upper bits control other functions of the peripheral, so they must not change while the transfer runs.

The caller pulses `start_i` together with a base value, a device byte, a sub-address byte and a value byte. The block captures all four and then plays out the sequence in this order: a start condition, three bytes each followed by an acknowledge slot, and a stop condition. It never reads an acknowledge. The acknowledge slot is clocked like an ordinary bit with data held low. A programmable settle interval separates consecutive writes. `busy_o` covers the whole transaction and `done_o` marks its end.

A typical use is loading a bias DAC: device byte 0x9C, sub-address 0x00, and the bias code as the value byte.

Top module: `sbus_regwrite_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy_o`, `wr_en_o` and `done_o` are all low.
- R2: A `start_i` seen in an idle cycle is accepted. In the next cycle `busy_o` is high and the first write strobe appears. `base_i`, `dev_i`, `sub_i` and `val_i` are captured at acceptance.
- R3: Every strobe carries address `REG_ADDR` (default 3). Its data bits 7:2 equal bits 7:2 of the captured base. Bits 1:0 of `base_i` have no effect.
- R4: The transaction opens with three writes whose bits {1,0} (data, clock) are 2'b11, 2'b01, 2'b00.
- R5: Each byte is sent most significant bit first. Every bit takes three writes with bits {1,0} equal to {d,0}, {d,1}, {d,0}.
- R6: After each byte comes an acknowledge slot: three writes with data 0 and clock 0, 1, 0. No input is sampled.
- R7: The bytes are sent in the order device, sub-address, value. A transaction has exactly 87 writes.
- R8: The transaction closes with three writes whose bits {1,0} are 2'b00, 2'b01, 2'b11.
- R9: Each strobe lasts one cycle. Consecutive strobes are exactly `SETTLE_CYC`+1 cycles apart.
- R10: `done_o` is a one-cycle pulse `SETTLE_CYC`+1 cycles after the last strobe. `busy_o` falls in that same cycle.
- R11: A `start_i` that arrives while `busy_o` is high is ignored: the running sequence is unchanged and no second transaction follows. Input changes during a transaction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request a transaction (accepted only when idle) |
| base_i | input | 8 | Base value; bits 7:2 are repeated in every write |
| dev_i | input | 8 | Device byte, sent first |
| sub_i | input | 8 | Sub-address byte, sent second |
| val_i | input | 8 | Value byte, sent third |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | 8 | Register data: base bits, data level, clock level |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Each position counter drives a visible bit directly, so a wrong value shows up at the very next strobe. A slipped phase, bit or byte counter alters the clock/data pair or the data bit within one settle interval. It also changes the total number of writes seen before `done_o`. A timer error changes the spacing between two strobes, which the bench measures strobe by strobe. A capture error, such as a base or byte register reloading while busy, corrupts the upper bits or the data bits of the strobes that follow the disturbing `start_i`.

// File: rtl/sbus_regwrite_pkg.sv
package sbus_regwrite_pkg;

  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = 3;
  localparam int SCL_POS    = 0;
  localparam int SDA_POS    = 1;
  localparam int SLOT_W     = $clog2(BYTE_W + 1);
  localparam int BSEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  typedef enum logic [1:0] {
    PH_OPEN  = 2'd0,
    PH_BYTES = 2'd1,
    PH_CLOSE = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_WRITE = 2'd1,
    CT_WAIT  = 2'd2
  } ctrl_t;

endpackage

// File: rtl/sbus_settle_timer.sv
module sbus_settle_timer #(
  parameter int SETTLE_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD); // R9

  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == RELOAD)); // R9

endmodule

// File: rtl/sbus_frame_seq.sv
module sbus_frame_seq
  import sbus_regwrite_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              adv_i,
  output phase_t            phase_o,
  output logic [1:0]        sub_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BSEL_W-1:0] bsel_o,
  output logic              last_o
);

  localparam logic [SLOT_W-1:0] ACK_SLOT  = SLOT_W'(BYTE_W);
  localparam logic [BSEL_W-1:0] LAST_BYTE = BSEL_W'(NUM_BYTES - 1);

  phase_t            phase_q, phase_d;
  logic [1:0]        sub_q, sub_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BSEL_W-1:0] bsel_q, bsel_d;
  logic              seq_en;

  always_comb begin
    seq_en  = clear_i | adv_i;
    phase_d = phase_q;
    sub_d   = sub_q;
    slot_d  = slot_q;
    bsel_d  = bsel_q;
    if (clear_i) begin
      phase_d = PH_OPEN;
      sub_d   = '0;
      slot_d  = '0;
      bsel_d  = '0;
    end else if (adv_i) begin
      if (sub_q != 2'd2) begin
        sub_d = sub_q + 2'd1;
      end else begin
        sub_d = '0;
        unique case (phase_q)
          PH_OPEN: begin
            phase_d = PH_BYTES;
            slot_d  = '0;
            bsel_d  = '0;
          end
          PH_BYTES: begin
            if (slot_q != ACK_SLOT) begin
              slot_d = slot_q + 1'b1;
            end else begin
              slot_d = '0;
              if (bsel_q != LAST_BYTE) bsel_d = bsel_q + 1'b1;
              else                     phase_d = PH_CLOSE;
            end
          end
          default: phase_d = phase_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPEN;
      sub_q   <= '0;
      slot_q  <= '0;
      bsel_q  <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      sub_q   <= sub_d;
      slot_q  <= slot_d;
      bsel_q  <= bsel_d;
    end
  end

  assign phase_o = phase_q;
  assign sub_o   = sub_q;
  assign slot_o  = slot_q;
  assign bsel_o  = bsel_q;
  assign last_o  = (phase_q == PH_CLOSE) && (sub_q == 2'd2);

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= 2'd2); // R5

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= ACK_SLOT); // R6

  AST_BYTE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bsel_q <= LAST_BYTE); // R7

  AST_CLOSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CLOSE) && !clear_i |=> (phase_q == PH_CLOSE)); // R8

endmodule

// File: rtl/sbus_line_encode.sv
module sbus_line_encode
  import sbus_regwrite_pkg::*;
(
  input  phase_t                      phase_i,
  input  logic [1:0]                  sub_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic [BSEL_W-1:0]           bsel_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] frame_i,
  input  logic [BYTE_W-1:0]           base_i,
  output logic [BYTE_W-1:0]           data_o
);

  logic [BYTE_W-1:0] cur_byte;
  logic [BYTE_W-1:0] shifted;
  logic              scl;
  logic              sda;

  always_comb begin
    cur_byte = frame_i[bsel_i*BYTE_W +: BYTE_W];
    shifted  = cur_byte << slot_i;
    scl = 1'b0;
    sda = 1'b0;
    unique case (phase_i)
      PH_OPEN: begin
        scl = (sub_i != 2'd2);
        sda = (sub_i == 2'd0);
      end
      PH_BYTES: begin
        scl = (sub_i == 2'd1);
        sda = (slot_i == SLOT_W'(BYTE_W)) ? 1'b0 : shifted[BYTE_W-1];
      end
      default: begin
        scl = (sub_i != 2'd0);
        sda = (sub_i == 2'd2);
      end
    endcase
    data_o          = base_i;
    data_o[SCL_POS] = scl;
    data_o[SDA_POS] = sda;
  end

endmodule

// File: rtl/sbus_regwrite_engine.sv
module sbus_regwrite_engine
  import sbus_regwrite_pkg::*;
#(
  parameter int SETTLE_CYC = 2000,
  parameter int ADDR_W     = 4,
  parameter int REG_ADDR   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        base_i,
  input  logic [7:0]        dev_i,
  input  logic [7:0]        sub_i,
  input  logic [7:0]        val_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              busy_o,
  output logic              done_o
);

  ctrl_t                       state_q, state_d;
  logic [BYTE_W-1:0]           base_q;
  logic [NUM_BYTES*BYTE_W-1:0] frame_q;
  logic                        done_q, done_d;
  logic                        accept;
  logic                        tmr_expired;
  logic                        seq_adv;
  logic                        seq_last;
  phase_t                      phase;
  logic [1:0]                  sub_pos;
  logic [SLOT_W-1:0]           slot_pos;
  logic [BSEL_W-1:0]           bsel;

  assign accept = (state_q == CT_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    seq_adv = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      CT_IDLE:  if (start_i) state_d = CT_WRITE;
      CT_WRITE: state_d = CT_WAIT;
      default: begin
        if (tmr_expired) begin
          if (seq_last) begin
            state_d = CT_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = CT_WRITE;
            seq_adv = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CT_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      frame_q <= '0;
    end else if (accept) begin
      base_q  <= base_i;
      frame_q <= {val_i, sub_i, dev_i};
    end
  end

  sbus_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (state_q == CT_WRITE),
    .run_i     (state_q == CT_WAIT),
    .expired_o (tmr_expired)
  );

  sbus_frame_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .adv_i   (seq_adv),
    .phase_o (phase),
    .sub_o   (sub_pos),
    .slot_o  (slot_pos),
    .bsel_o  (bsel),
    .last_o  (seq_last)
  );

  sbus_line_encode u_enc (
    .phase_i (phase),
    .sub_i   (sub_pos),
    .slot_i  (slot_pos),
    .bsel_i  (bsel),
    .frame_i (frame_q),
    .base_i  (base_q),
    .data_o  (wr_data_o)
  );

  assign wr_en_o   = (state_q == CT_WRITE);
  assign wr_addr_o = ADDR_W'(REG_ADDR);
  assign busy_o    = (state_q != CT_IDLE);
  assign done_o    = done_q;

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o); // R9

  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o); // R2

  AST_START_TO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (wr_en_o && busy_o)); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !wr_en_o)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(frame_q) && $stable(base_q))); // R11

  AST_BASE_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(busy_o)) |-> (wr_data_o[7:2] == $past(wr_data_o[7:2]))); // R3

endmodule

// File: tb/tb_sbus_regwrite_engine.sv
`timescale 1ns/1ps
module tb_sbus_regwrite_engine;

  localparam int S      = 4;
  localparam int ADDR_W = 4;
  localparam int RADDR  = 3;
  localparam int NWR    = 87;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [7:0]        base_i, dev_i, sub_i, val_i;
  logic              wr_en_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [7:0]        wr_data_o;
  logic              busy_o;
  logic              done_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  logic [7:0] exp_q [NWR];

  sbus_regwrite_engine #(.SETTLE_CYC(S), .ADDR_W(ADDR_W), .REG_ADDR(RADDR)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .dev_i(dev_i),
    .sub_i(sub_i), .val_i(val_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [7:0] wv(input logic [7:0] b, input bit d, input bit c);
    return {b[7:2], d, c};
  endfunction

  task automatic build_exp(input logic [7:0] b, input logic [7:0] dv,
                           input logic [7:0] sb, input logic [7:0] vl);
    int n;
    logic [7:0] by [3];
    by[0] = dv; by[1] = sb; by[2] = vl;
    exp_q[0] = wv(b, 1, 1); exp_q[1] = wv(b, 0, 1); exp_q[2] = wv(b, 0, 0);
    n = 3;
    for (int k = 0; k < 3; k++) begin
      for (int i = 7; i >= 0; i--) begin
        exp_q[n] = wv(b, by[k][i], 0); exp_q[n+1] = wv(b, by[k][i], 1);
        exp_q[n+2] = wv(b, by[k][i], 0); n += 3;
      end
      exp_q[n] = wv(b, 0, 0); exp_q[n+1] = wv(b, 0, 1); exp_q[n+2] = wv(b, 0, 0);
      n += 3;
    end
    exp_q[n] = wv(b, 0, 0); exp_q[n+1] = wv(b, 0, 1); exp_q[n+2] = wv(b, 1, 1);
  endtask

  function automatic string req_of(input int idx);
    int u;
    if (idx < 3) return "R4";
    if (idx >= NWR - 3) return "R8";
    u = (idx - 3) / 3;
    if (u % 9 == 8) return "R6";
    return "R5/R7";
  endfunction

  task automatic run_txn(input logic [7:0] b, input logic [7:0] dv, input logic [7:0] sb,
                         input logic [7:0] vl, input bit poke);
    int idx, last_t, limit;
    bit fin;
    build_exp(b, dv, sb, vl);
    @(negedge clk);
    base_i = b; dev_i = dv; sub_i = sb; val_i = vl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1 && wr_en_o === 1'b1, "R2", {busy_o, wr_en_o}, 3);
    idx = 0; last_t = 0; fin = 0; limit = NWR * (S + 1) + 50;
    for (int t = 0; t < limit && !fin; t++) begin
      if (wr_en_o === 1'b1) begin
        if (idx < NWR) begin
          check(wr_addr_o == ADDR_W'(RADDR), "R3 addr", wr_addr_o, RADDR);
          check(wr_data_o === exp_q[idx], req_of(idx), wr_data_o, exp_q[idx]);
        end
        if (idx > 0) check(t - last_t == S + 1, "R9 gap", t - last_t, S + 1);
        idx++; last_t = t;
      end
      if (done_o === 1'b1) begin
        check(busy_o === 1'b0, "R10 busy", busy_o, 0);
        check(t - last_t == S + 1, "R10 delay", t - last_t, S + 1);
        check(idx == NWR, "R7 count", idx, NWR);
        fin = 1;
      end
      if (!fin) begin
        if (poke && idx == 40 && wr_en_o === 1'b1) begin
          base_i = ~b; dev_i = ~dv; sub_i = ~sb; val_i = ~vl; start_i = 1'b1; // R11
        end else begin
          start_i = 1'b0;
        end
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    check(fin, "R10 done seen", fin, 1);
    for (int k = 0; k < 3 * (S + 1); k++) begin
      @(negedge clk);
      check(wr_en_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R11 idle after",
            {wr_en_o, busy_o, done_o}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; start_i = 1'b0;
    base_i = '0; dev_i = '0; sub_i = '0; val_i = '0;
    repeat (3) @(negedge clk);
    check(wr_en_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 in reset",
          {wr_en_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_en_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 after reset",
          {wr_en_o, busy_o, done_o}, 0);
    run_txn(8'hFF, 8'h9C, 8'h00, 8'h7D, 1'b0);
    run_txn(8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0);
    run_txn(8'hA7, 8'h00, 8'h80, 8'h01, 1'b1);
    run_txn(8'h13, 8'h9C, 8'h00, 8'h00, 1'b1);
    for (int r = 0; r < 16; r++)
      run_txn(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), r[0]);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule